// File: doc/BRIEF.md
# Scatter-Gather Burst Request Generator

This block walks the buffer list of one transfer command and turns it into a stream of memory burst requests for a separate data mover. A command is given as the base address of its table and a count of buffer descriptors. The descriptors start 128 bytes past the table base and are 16 bytes each. The block fetches them one at a time through a narrow read port, splits each buffer into bursts, and hands out each burst as an address, a byte length and a direction.

Bursts never cross a burst-size boundary. The first burst of a buffer is cut short to reach the next boundary, and the last burst carries whatever bytes remain. A buffer with a byte count of zero gives no burst. The block adds up the byte counts of all descriptors. When the list is finished it gives a one-cycle completion pulse together with that total. If the total is not a whole number of device blocks, an error pulse is given instead of the completion pulse.

Top module: `sgb_burst_gen`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `error`, `brq_valid` and `desc_rd_valid` are low.
- R2: A `start` seen while idle latches `cmd_table`, `cmd_nbuf` and `cmd_write`. Descriptor i is then read once from `cmd_table + 128 + 16*i`, with i counting up from 0. A `start` that arrives while `busy` is high is ignored.
- R3: A descriptor arrives as 128/DW little-endian beats on `desc_rsp_data`. Bytes 0-3 hold the low half of the buffer address, bytes 4-7 hold the high half, bytes 8-11 are ignored and bytes 12-15 hold the byte count. With DW=64, beat 0 is {addr_hi, addr_lo} and beat 1 is {count, ignored}.
- R4: Each burst has length min(BURST_BYTES - (addr mod BURST_BYTES), remaining). Each burst of a buffer starts where the previous one ended, no burst crosses a BURST_BYTES boundary, and the lengths add up to the buffer's byte count.
- R5: A descriptor whose byte count is zero produces no burst, and the walk moves on to the next descriptor.
- R6: `brq_write` equals the `cmd_write` value latched at start for every burst of the command, whatever `cmd_write` does later.
- R7: A request that is offered (`brq_valid` or `desc_rd_valid`) stays offered with its address, length and direction unchanged until it is accepted by the matching ready. The two request ports are never active in the same cycle.
- R8: Once the final burst is accepted (or the final descriptor is read, if its count is zero), a single-cycle `done` pulse is given. During that pulse `total_bytes` equals the sum of all descriptor counts, provided that sum is a multiple of BLOCK_BYTES.
- R9: If the sum is not a multiple of BLOCK_BYTES, a single-cycle `error` pulse is given in place of `done`. `done` and `error` are never high together.
- R10: A `cmd_nbuf` of 0 reads no descriptor and gives `done` with a total of 0. A `cmd_nbuf` above MAX_DESC (248) is treated as MAX_DESC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (sampled while idle) |
| cmd_table | input | AW | Command table base address |
| cmd_nbuf | input | IDXW | Number of buffer descriptors |
| cmd_write | input | 1 | Direction of the command, 1 = memory read for a device write |
| desc_rd_valid | output | 1 | Descriptor read request |
| desc_rd_ready | input | 1 | Descriptor read accepted |
| desc_rd_addr | output | AW | Byte address of the 16-byte descriptor |
| desc_rsp_valid | input | 1 | Descriptor data beat valid |
| desc_rsp_data | input | DW | Descriptor data beat |
| brq_valid | output | 1 | Burst request valid |
| brq_ready | input | 1 | Burst request accepted |
| brq_addr | output | AW | Burst start byte address |
| brq_len | output | LENW | Burst length in bytes (1 to BURST_BYTES) |
| brq_write | output | 1 | Direction of the burst |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished with a whole number of blocks |
| error | output | 1 | Command finished with a partial block |
| total_bytes | output | TOTW | Sum of descriptor byte counts |

## Verification
The remaining-byte count and the burst address live in one register pair. If that pair goes wrong, the very next accepted burst shows a wrong address or length at `brq_addr` and `brq_len`, and the error then runs on into every later burst of the same buffer. A wrong descriptor index is seen at the next `desc_rd_addr`, one read later. A wrong accumulator or a wrong end-of-list test can only be seen at the end of the command, as a wrong `total_bytes`, the wrong choice between `done` and `error`, or a completion that comes too early or too late compared with the number of reads and bursts.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
  typedef enum logic [2:0] {
    SG_IDLE,
    SG_FETCH,
    SG_GATHER,
    SG_SPLIT,
    SG_FINISH
  } sg_state_e;

  // 16-byte buffer descriptor, byte 0 in the least significant bits
  typedef struct packed {
    logic [31:0] count;
    logic [31:0] rsvd;
    logic [31:0] addr_hi;
    logic [31:0] addr_lo;
  } sg_desc_t;

  localparam int unsigned SG_HDR_BYTES  = 128;
  localparam int unsigned SG_DESC_SHIFT = 4;
endpackage

// File: rtl/sgb_desc_gather.sv
module sgb_desc_gather
  import sgb_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_valid,
  input  logic [DW-1:0] beat_data,
  output sg_desc_t      desc_o,
  output logic          desc_valid_o
);
  localparam int unsigned BEATS = 128 / DW;
  localparam int unsigned BEATW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [127:0]     word_q;
  logic [BEATW-1:0] beat_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (beat_valid) begin
        word_q[beat_q*DW +: DW] <= beat_data;
        if (beat_q == BEATW'(BEATS - 1)) begin
          beat_q  <= '0;
          valid_q <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign desc_o       = word_q;
  assign desc_valid_o = valid_q;
endmodule

// File: rtl/sgb_burst_split.sv
module sgb_burst_split #(
  parameter int unsigned AW          = 64,
  parameter int unsigned CNTW        = 32,
  parameter int unsigned BURST_BYTES = 16,
  localparam int unsigned OFFW       = $clog2(BURST_BYTES),
  localparam int unsigned LENW       = OFFW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   load_addr,
  input  logic [CNTW-1:0] load_cnt,
  input  logic            step,
  output logic [AW-1:0]   addr_o,
  output logic [LENW-1:0] len_o,
  output logic            last_o
);
  // bytes left before the next burst-size boundary
  function automatic logic [LENW-1:0] room_to_boundary(input logic [AW-1:0] a);
    return LENW'(BURST_BYTES) - LENW'(a[OFFW-1:0]);
  endfunction

  function automatic logic [LENW-1:0] clip_len(input logic [CNTW-1:0] rem,
                                                input logic [LENW-1:0] room);
    return (rem < CNTW'(room)) ? rem[LENW-1:0] : room;
  endfunction

  logic [AW-1:0]   addr_q;
  logic [CNTW-1:0] rem_q;
  logic [LENW-1:0] len;

  assign len    = clip_len(rem_q, room_to_boundary(addr_q));
  assign addr_o = addr_q;
  assign len_o  = len;
  assign last_o = (rem_q == CNTW'(len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      rem_q  <= load_cnt;
    end else if (step) begin
      addr_q <= addr_q + AW'(len);
      rem_q  <= rem_q - CNTW'(len);
    end
  end
endmodule

// File: rtl/sgb_burst_gen.sv
module sgb_burst_gen
  import sgb_pkg::*;
#(
  parameter int unsigned AW          = 64,
  parameter int unsigned DW          = 64,
  parameter int unsigned BURST_BYTES = 16,
  parameter int unsigned BLOCK_BYTES = 512,
  parameter int unsigned MAX_DESC    = 248,
  parameter int unsigned CNTW        = 32,
  localparam int unsigned IDXW       = $clog2(MAX_DESC + 1),
  localparam int unsigned LENW       = $clog2(BURST_BYTES) + 1,
  localparam int unsigned TOTW       = CNTW + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cmd_table,
  input  logic [IDXW-1:0] cmd_nbuf,
  input  logic            cmd_write,
  output logic            desc_rd_valid,
  input  logic            desc_rd_ready,
  output logic [AW-1:0]   desc_rd_addr,
  input  logic            desc_rsp_valid,
  input  logic [DW-1:0]   desc_rsp_data,
  output logic            brq_valid,
  input  logic            brq_ready,
  output logic [AW-1:0]   brq_addr,
  output logic [LENW-1:0] brq_len,
  output logic            brq_write,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic [TOTW-1:0] total_bytes
);
  localparam int unsigned BLKW = $clog2(BLOCK_BYTES);

  function automatic logic [AW-1:0] desc_addr_of(input logic [AW-1:0]   base,
                                                 input logic [IDXW-1:0] idx);
    return base + AW'(SG_HDR_BYTES) + (AW'(idx) << SG_DESC_SHIFT);
  endfunction

  function automatic logic [IDXW-1:0] clamp_count(input logic [IDXW-1:0] n);
    return (n > IDXW'(MAX_DESC)) ? IDXW'(MAX_DESC) : n;
  endfunction

  function automatic logic whole_blocks(input logic [TOTW-1:0] t);
    return t[BLKW-1:0] == '0;
  endfunction

  sg_state_e       state_q;
  logic [AW-1:0]   base_q;
  logic [IDXW-1:0] nbuf_q;
  logic [IDXW-1:0] idx_q;
  logic            write_q;
  logic [TOTW-1:0] total_q;

  sg_desc_t        desc;
  logic            desc_valid;
  logic [63:0]     desc_full_addr;
  logic            unused_rsvd;

  logic [AW-1:0]   split_addr;
  logic [LENW-1:0] split_len;

  // named internal events
  logic ev_desc_req_fire;
  logic ev_desc_arrive;
  logic ev_desc_empty;
  logic ev_burst_fire;
  logic ev_burst_last;
  logic ev_last_desc;
  logic ev_finish;

  assign desc_full_addr   = {desc.addr_hi, desc.addr_lo};
  assign unused_rsvd      = ^desc.rsvd;
  assign ev_desc_req_fire = desc_rd_valid && desc_rd_ready;
  assign ev_desc_arrive   = desc_valid && (state_q == SG_GATHER);
  assign ev_desc_empty    = ev_desc_arrive && (desc.count == '0);
  assign ev_burst_fire    = brq_valid && brq_ready;
  assign ev_last_desc     = (idx_q == nbuf_q - 1'b1);
  assign ev_finish        = (state_q == SG_FINISH);

  sgb_desc_gather #(.DW(DW)) u_gather (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_valid  (desc_rsp_valid && (state_q == SG_GATHER)),
    .beat_data   (desc_rsp_data),
    .desc_o      (desc),
    .desc_valid_o(desc_valid)
  );

  sgb_burst_split #(
    .AW         (AW),
    .CNTW       (CNTW),
    .BURST_BYTES(BURST_BYTES)
  ) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_desc_arrive && !ev_desc_empty),
    .load_addr(desc_full_addr[AW-1:0]),
    .load_cnt (desc.count),
    .step     (ev_burst_fire),
    .addr_o   (split_addr),
    .len_o    (split_len),
    .last_o   (ev_burst_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SG_IDLE;
      base_q  <= '0;
      nbuf_q  <= '0;
      idx_q   <= '0;
      write_q <= 1'b0;
      total_q <= '0;
    end else begin
      unique case (state_q)
        SG_IDLE: if (start) begin
          base_q  <= cmd_table;
          nbuf_q  <= clamp_count(cmd_nbuf);
          write_q <= cmd_write;
          idx_q   <= '0;
          total_q <= '0;
          state_q <= (clamp_count(cmd_nbuf) == '0) ? SG_FINISH : SG_FETCH;
        end
        SG_FETCH: if (ev_desc_req_fire) state_q <= SG_GATHER;
        SG_GATHER: if (ev_desc_arrive) begin
          total_q <= total_q + TOTW'(desc.count);
          if (!ev_desc_empty) begin
            state_q <= SG_SPLIT;
          end else if (ev_last_desc) begin
            state_q <= SG_FINISH;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SG_FETCH;
          end
        end
        SG_SPLIT: if (ev_burst_fire && ev_burst_last) begin
          if (ev_last_desc) begin
            state_q <= SG_FINISH;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SG_FETCH;
          end
        end
        SG_FINISH: state_q <= SG_IDLE;
        default:   state_q <= SG_IDLE;
      endcase
    end
  end

  assign desc_rd_valid = (state_q == SG_FETCH);
  assign desc_rd_addr  = desc_addr_of(base_q, idx_q);
  assign brq_valid     = (state_q == SG_SPLIT);
  assign brq_addr      = split_addr;
  assign brq_len       = split_len;
  assign brq_write     = write_q;
  assign busy          = (state_q != SG_IDLE);
  assign done          = ev_finish && whole_blocks(total_q);
  assign error         = ev_finish && !whole_blocks(total_q);
  assign total_bytes   = total_q;
endmodule

// File: rtl/sgb_checker.sv
module sgb_checker #(
  parameter int unsigned AW          = 64,
  parameter int unsigned BURST_BYTES = 16,
  parameter int unsigned BLOCK_BYTES = 512,
  parameter int unsigned LENW        = 5,
  parameter int unsigned TOTW        = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            desc_rd_valid,
  input logic            desc_rd_ready,
  input logic [AW-1:0]   desc_rd_addr,
  input logic            brq_valid,
  input logic            brq_ready,
  input logic [AW-1:0]   brq_addr,
  input logic [LENW-1:0] brq_len,
  input logic            brq_write,
  input logic            done,
  input logic            error,
  input logic [TOTW-1:0] total_bytes,
  input logic            ev_burst_fire,
  input logic            ev_burst_last
);
  localparam int unsigned OFFW = $clog2(BURST_BYTES);
  localparam int unsigned BLKW = $clog2(BLOCK_BYTES);
  localparam int unsigned SW   = LENW + 1;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!brq_valid && !desc_rd_valid && !done && !error));

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brq_valid |-> (brq_len != '0 && brq_len <= LENW'(BURST_BYTES)));

  p_no_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brq_valid |-> (SW'(brq_addr[OFFW-1:0]) + SW'(brq_len) <= SW'(BURST_BYTES)));

  p_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_burst_fire && !ev_burst_last) |=>
      (brq_valid && brq_addr == $past(brq_addr) + AW'($past(brq_len))));

  p_brq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brq_valid && !brq_ready) |=>
      (brq_valid && $stable(brq_addr) && $stable(brq_len) && $stable(brq_write)));

  p_desc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_rd_valid && !desc_rd_ready) |=> (desc_rd_valid && $stable(desc_rd_addr)));

  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brq_valid, desc_rd_valid}));

  p_done_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (total_bytes[BLKW-1:0] == '0));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> !(done || error));

  p_err_partial_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (total_bytes[BLKW-1:0] != '0));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error}));
endmodule

bind sgb_burst_gen sgb_checker #(
  .AW         (AW),
  .BURST_BYTES(BURST_BYTES),
  .BLOCK_BYTES(BLOCK_BYTES),
  .LENW       (LENW),
  .TOTW       (TOTW)
) u_sgb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .desc_rd_valid(desc_rd_valid),
  .desc_rd_ready(desc_rd_ready),
  .desc_rd_addr (desc_rd_addr),
  .brq_valid    (brq_valid),
  .brq_ready    (brq_ready),
  .brq_addr     (brq_addr),
  .brq_len      (brq_len),
  .brq_write    (brq_write),
  .done         (done),
  .error        (error),
  .total_bytes  (total_bytes),
  .ev_burst_fire(ev_burst_fire),
  .ev_burst_last(ev_burst_last)
);

// File: tb/sgb_burst_gen_test.sv
module sgb_burst_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 64;
  localparam int DW    = 64;
  localparam int BURST = 16;
  localparam int BLOCK = 512;
  localparam int MAXD  = 248;
  localparam int IDXW  = 8;
  localparam int LENW  = 5;
  localparam int TOTW  = 40;
  localparam int BEATS = 128 / DW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [AW-1:0]   cmd_table;
  logic [IDXW-1:0] cmd_nbuf;
  logic            cmd_write;
  logic            desc_rd_valid, desc_rd_ready;
  logic [AW-1:0]   desc_rd_addr;
  logic            desc_rsp_valid;
  logic [DW-1:0]   desc_rsp_data;
  logic            brq_valid, brq_ready;
  logic [AW-1:0]   brq_addr;
  logic [LENW-1:0] brq_len;
  logic            brq_write;
  logic            busy, done, error;
  logic [TOTW-1:0] total_bytes;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sgb_burst_gen #(
    .AW(AW), .DW(DW), .BURST_BYTES(BURST), .BLOCK_BYTES(BLOCK), .MAX_DESC(MAXD), .CNTW(32)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_table(cmd_table), .cmd_nbuf(cmd_nbuf),
    .cmd_write(cmd_write), .desc_rd_valid(desc_rd_valid), .desc_rd_ready(desc_rd_ready),
    .desc_rd_addr(desc_rd_addr), .desc_rsp_valid(desc_rsp_valid), .desc_rsp_data(desc_rsp_data),
    .brq_valid(brq_valid), .brq_ready(brq_ready), .brq_addr(brq_addr), .brq_len(brq_len),
    .brq_write(brq_write), .busy(busy), .done(done), .error(error), .total_bytes(total_bytes)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_lo [256];
  logic [31:0] m_hi [256];
  logic [31:0] m_cnt[256];
  logic [63:0] e_addr[2048];
  int          e_len [2048];
  int          e_n;
  logic [63:0] e_total;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // length of the next piece: up to the next multiple of BURST, capped by rem
  function automatic int piece_len(input logic [63:0] a, input int rem);
    logic [63:0] nb;
    logic [63:0] room;
    nb   = (a / BURST + 1) * BURST;
    room = nb - a;
    return (room > 64'(rem)) ? rem : int'(room);
  endfunction

  task automatic build_expect(input int eff);
    e_n = 0;
    e_total = 0;
    for (int i = 0; i < eff; i++) begin
      logic [63:0] a;
      int rem;
      a = {m_hi[i], m_lo[i]};
      rem = int'(m_cnt[i]);
      e_total += 64'(m_cnt[i]);
      while (rem > 0) begin
        int l;
        l = piece_len(a, rem);
        if (e_n < 2048) begin
          e_addr[e_n] = a;
          e_len[e_n]  = l;
        end
        e_n++;
        a += 64'(l);
        rem -= l;
      end
    end
  endtask

  task automatic clear_list();
    for (int i = 0; i < 256; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_cnt[i] = 0;
    end
  endtask

  // caller is at a falling edge
  task automatic run_cmd(input logic [63:0] base, input int n, input bit wr);
    int eff, bp, rd_n, pend_beats, pend_idx, iter, sl;
    bit armed, stall, exp_err;
    logic [63:0] sa;
    logic [127:0] dword;
    eff = (n > MAXD) ? MAXD : n;
    build_expect(eff);
    exp_err = (e_total % BLOCK) != 0;
    bp = 0; rd_n = 0; pend_beats = 0; pend_idx = 0; iter = 0; sl = 0;
    armed = 0; stall = 0; sa = 0;
    start = 1'b1; cmd_table = base; cmd_nbuf = IDXW'(n); cmd_write = wr;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", 64'(busy), 64'd1);
    while (1) begin
      // R2: a start while busy must be ignored; R6: direction input changes later
      if (iter == 3) begin
        start = 1'b1; cmd_table = base ^ 64'h5000; cmd_nbuf = 8'd3; cmd_write = ~wr;
      end else begin
        start = 1'b0;
      end
      if (done || error) break;
      if (iter > 30000) begin
        n_vec++; n_bad++;
        $display("FAIL R8 watchdog: actual no completion expected completion");
        break;
      end
      if (stall) begin
        chk("R7", "held burst valid", 64'(brq_valid), 64'd1);
        chk("R7", "held burst addr", brq_addr, sa);
        chk("R7", "held burst len", 64'(brq_len), 64'(sl));
      end
      brq_ready = 1'b0;
      stall = 0;
      if (brq_valid) begin
        chk("R7", "one request port", 64'(desc_rd_valid), 64'd0);
        brq_ready = ($urandom % 4) != 0;
        if (brq_ready) begin
          if (bp < e_n && bp < 2048) begin
            chk("R4", "burst addr", brq_addr, e_addr[bp]);
            chk("R4", "burst len", 64'(brq_len), 64'(e_len[bp]));
          end else begin
            chk("R5", "extra burst", 64'(bp), 64'(e_n));
          end
          chk("R6", "burst direction", 64'(brq_write), 64'(wr));
          bp++;
        end else begin
          stall = 1; sa = brq_addr; sl = int'(brq_len);
        end
      end
      desc_rsp_valid = 1'b0;
      if (pend_beats > 0 && armed && ($urandom % 3) != 0) begin
        dword = {m_cnt[pend_idx], 32'hC0DE_0000 ^ 32'(pend_idx), m_hi[pend_idx], m_lo[pend_idx]};
        desc_rsp_valid = 1'b1;
        desc_rsp_data  = dword[(BEATS - pend_beats) * DW +: DW];
        pend_beats--;
      end
      armed = (pend_beats > 0);
      desc_rd_ready = 1'b0;
      if (desc_rd_valid) begin
        desc_rd_ready = ($urandom % 3) != 0;
        if (desc_rd_ready) begin
          chk("R2", "descriptor addr", desc_rd_addr, base + 64'd128 + 64'(rd_n) * 64'd16);
          pend_idx = rd_n & 255; pend_beats = BEATS; armed = 0;
          rd_n++;
        end
      end
      iter++;
      @(negedge clk);
    end
    start = 1'b0; brq_ready = 1'b0; desc_rd_ready = 1'b0; desc_rsp_valid = 1'b0;
    chk("R8", "done flag", 64'(done), 64'(!exp_err));
    chk("R9", "error flag", 64'(error), 64'(exp_err));
    chk("R8", "total bytes", 64'(total_bytes), e_total);
    chk("R5", "burst count", 64'(bp), 64'(e_n));
    chk("R10", "descriptor reads", 64'(rd_n), 64'(eff));
    @(negedge clk);
    chk("R8", "single pulse", 64'(done || error), 64'd0);
    chk("R1", "idle after finish", 64'({busy, brq_valid, desc_rd_valid}), 64'd0);
  endtask

  initial begin
    logic [31:0] sum;
    void'($urandom(32'd7341));
    rst_n = 1'b0; start = 1'b0; cmd_table = '0; cmd_nbuf = '0; cmd_write = 1'b0;
    desc_rd_ready = 1'b0; desc_rsp_valid = 1'b0; desc_rsp_data = '0; brq_ready = 1'b0;
    clear_list();
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", 64'({busy, done, error, brq_valid, desc_rd_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle outputs", 64'({busy, done, error, brq_valid, desc_rd_valid}), 64'd0);

    // R4: aligned buffer of one block, all full bursts
    clear_list();
    m_lo[0] = 32'h1000; m_cnt[0] = 512;
    run_cmd(64'h0000_0000_0008_0000, 1, 1'b0);

    // R3 high address word, R4 short first burst, R5 empty buffer
    clear_list();
    m_lo[0] = 32'h2005; m_hi[0] = 32'h1; m_cnt[0] = 27;
    m_lo[1] = 32'h9999; m_cnt[1] = 0;
    m_lo[2] = 32'h3003; m_cnt[2] = 5;
    m_lo[3] = 32'h400F; m_hi[3] = 32'hABCD_0123; m_cnt[3] = 480;
    run_cmd(64'h0000_0020_0000_1000, 4, 1'b1);

    // R9: partial block total
    clear_list();
    m_lo[0] = 32'h100; m_cnt[0] = 100;
    m_lo[1] = 32'h207; m_cnt[1] = 30;
    run_cmd(64'h7000, 2, 1'b0);

    // R10: empty list
    clear_list();
    run_cmd(64'h9000, 0, 1'b1);

    // R10: count above the maximum is clamped
    clear_list();
    run_cmd(64'hA000, 255, 1'b0);

    // random commands
    for (int r = 0; r < 40; r++) begin
      int n;
      logic [63:0] base;
      clear_list();
      n = 1 + int'($urandom % 6);
      base = {$urandom, $urandom} & ~64'hF;
      sum = 0;
      for (int i = 0; i < n; i++) begin
        m_lo[i]  = $urandom;
        m_hi[i]  = (($urandom % 2) != 0) ? $urandom : 32'd0;
        m_cnt[i] = (($urandom % 5) == 0) ? 32'd0 : 32'd1 + ($urandom % 300);
        sum += m_cnt[i];
      end
      if (($urandom % 2) != 0)
        m_cnt[n-1] += (BLOCK - (sum % BLOCK)) % BLOCK;
      run_cmd(base, n, bit'($urandom % 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule